// File: doc/BRIEF.md
# TLB Invalidation Match Engine

This block holds a small fully associative translation table and removes entries from it on command. Each slot stores a valid flag, a global flag, an address-space identifier (ASID), a virtual page number (VPN), a guest identifier (GID) and a one-bit stage tag. A stage tag of 0 marks a first-stage mapping (guest virtual to guest physical). A stage tag of 1 marks a second-stage mapping (guest physical to host physical). An invalidate command carries a 5-bit operation code, an ASID, a GID and a VPN. The operation code selects one rule built from the global flag, ASID equality, VPN equality, GID equality, equality with a programmable current GID, and the stage tag. Every valid entry that satisfies the rule loses its valid flag.

All slots are compared at once, so one command takes effect in a single clock edge. A one-cycle completion pulse follows it, or a one-cycle illegal pulse when the code is not defined. Entries are loaded through a write port. The slot comes either from an explicit index or from a free-running slot counter. A search port reports whether a key is present and, if it is, the lowest slot that holds it. Software-style sequencing, meaning load, invalidate and probe, is driven entirely from these ports.

Top module: `tlbinv_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it, no slot is valid, `inv_done`, `inv_illegal` and `srch_hit` are 0, and a search finds nothing.
- R2: `wr_en` with `wr_random`=0 stores the given fields into slot `wr_index` and marks it valid at the next clock edge.
- R3: `fill_slot` advances by one (modulo the slot count) on every clock edge after reset. A write with `wr_random`=1 uses the `fill_slot` value present on that edge.
- R4: A search registers its result one cycle after `srch_en`. An entry matches when it is valid, its VPN and GID equal the key, and it is global or its ASID equals the key. `srch_idx` is the lowest matching slot.
- R5: Codes 0x00 to 0x03: 0x00 removes every entry. 0x01 removes entries whose GID equals the current GID register. 0x02 removes those entries only when global=1. 0x03 removes them only when global=0.
- R6: Codes 0x04 to 0x06: 0x04 removes global=0 entries with equal ASID. 0x05 additionally needs an equal VPN. 0x06 needs an equal VPN and either global=1 or an equal ASID.
- R7: Codes 0x09, 0x0A and 0x0B remove entries with equal GID: regardless of the global flag, only global=1, and only global=0, respectively.
- R8: Code 0x0C removes entries with equal GID, global=0 and equal ASID. 0x0D additionally needs an equal VPN. 0x0E needs an equal GID, global=1, an equal ASID and an equal VPN.
- R9: Codes 0x10, 0x11 and 0x12 remove, for any GID, the stage-0 entries, the stage-1 entries, and all entries, respectively.
- R10: Codes 0x13, 0x14 and 0x15 do the same as R9 but only for entries with equal GID. Code 0x16 needs an equal GID, stage tag 1 and an equal VPN.
- R11: Any other code changes no entry. It raises `inv_illegal` for exactly the one cycle after the command and does not raise `inv_done`.
- R12: A defined code clears every matching entry at the clock edge on which `inv_req` is sampled. `inv_done` is high for exactly the following cycle and `inv_illegal` stays 0.
- R13: `ctx_we` loads `ctx_gid` into the current GID register, which is 0 after reset. That register decides which entries codes 0x01 to 0x03 treat as current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_we | input | 1 | Load current GID register |
| ctx_gid | input | GID_W | New current GID |
| wr_en | input | 1 | Write an entry |
| wr_random | input | 1 | 1: slot from `fill_slot`, 0: slot from `wr_index` |
| wr_index | input | IW | Explicit write slot |
| wr_global | input | 1 | Global flag of the new entry |
| wr_stage | input | 1 | Stage tag of the new entry (0 first, 1 second) |
| wr_asid | input | ASID_W | ASID of the new entry |
| wr_vpn | input | VPN_W | VPN of the new entry |
| wr_gid | input | GID_W | GID of the new entry |
| inv_req | input | 1 | Invalidate command strobe |
| inv_op | input | 5 | Invalidate operation code |
| inv_asid | input | ASID_W | Command ASID |
| inv_gid | input | GID_W | Command GID |
| inv_vpn | input | VPN_W | Command VPN |
| inv_done | output | 1 | Pulse after a defined command |
| inv_illegal | output | 1 | Pulse after an undefined command |
| srch_en | input | 1 | Search strobe |
| srch_asid | input | ASID_W | Search key ASID |
| srch_vpn | input | VPN_W | Search key VPN |
| srch_gid | input | GID_W | Search key GID |
| srch_hit | output | 1 | Search found a valid match |
| srch_idx | output | IW | Lowest matching slot |
| fill_slot | output | IW | Slot counter used by random writes |

## Verification
The main sweep covers all 32 operation codes against all 16 address choices. Before each command it reloads the table with a population whose slot number encodes the global flag, the stage tag, target-versus-current GID and matching-versus-other ASID, with a distinct VPN per slot. A probe of every slot afterwards separates each predicate from its neighbours: global polarity, stage choice, GID versus current-context scoping, and whether the address term is used. The undefined codes in the same sweep show that nothing changes. Directed cases cover the lowest-index choice among duplicate keys, a global entry found under a foreign ASID, the random slot, and a change of the current GID register.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [1:0] {
    GSEL_ANY = 2'd0,
    GSEL_SET = 2'd1,
    GSEL_CLR = 2'd2
  } gsel_e;

  typedef enum logic [1:0] {
    SSEL_ANY    = 2'd0,
    SSEL_FIRST  = 2'd1,
    SSEL_SECOND = 2'd2
  } ssel_e;

  // Which terms an invalidate command requires of an entry.
  typedef struct packed {
    logic  legal;
    logic  use_ctx;
    logic  use_gid;
    logic  use_asid;
    logic  use_va;
    logic  g_or_asid;
    gsel_e gsel;
    ssel_e ssel;
  } inv_rule_t;

  localparam logic STAGE_FIRST  = 1'b0;
  localparam logic STAGE_SECOND = 1'b1;

endpackage

// File: rtl/tlbinv_decode.sv
module tlbinv_decode
  import tlbinv_pkg::*;
(
  input  logic [4:0] op,
  output inv_rule_t  rule
);
  always_comb begin
    rule = '{legal: 1'b1, use_ctx: 1'b0, use_gid: 1'b0, use_asid: 1'b0,
             use_va: 1'b0, g_or_asid: 1'b0, gsel: GSEL_ANY, ssel: SSEL_ANY};
    case (op)
      5'h00: ;
      5'h01: rule.use_ctx = 1'b1;
      5'h02: begin rule.use_ctx = 1'b1; rule.gsel = GSEL_SET; end
      5'h03: begin rule.use_ctx = 1'b1; rule.gsel = GSEL_CLR; end
      5'h04: begin rule.use_asid = 1'b1; rule.gsel = GSEL_CLR; end
      5'h05: begin rule.use_asid = 1'b1; rule.use_va = 1'b1; rule.gsel = GSEL_CLR; end
      5'h06: begin rule.use_va = 1'b1; rule.g_or_asid = 1'b1; end
      5'h09: rule.use_gid = 1'b1;
      5'h0A: begin rule.use_gid = 1'b1; rule.gsel = GSEL_SET; end
      5'h0B: begin rule.use_gid = 1'b1; rule.gsel = GSEL_CLR; end
      5'h0C: begin rule.use_gid = 1'b1; rule.use_asid = 1'b1; rule.gsel = GSEL_CLR; end
      5'h0D: begin
        rule.use_gid = 1'b1; rule.use_asid = 1'b1; rule.use_va = 1'b1;
        rule.gsel = GSEL_CLR;
      end
      5'h0E: begin
        rule.use_gid = 1'b1; rule.use_asid = 1'b1; rule.use_va = 1'b1;
        rule.gsel = GSEL_SET;
      end
      5'h10: rule.ssel = SSEL_FIRST;
      5'h11: rule.ssel = SSEL_SECOND;
      5'h12: ;
      5'h13: begin rule.use_gid = 1'b1; rule.ssel = SSEL_FIRST; end
      5'h14: begin rule.use_gid = 1'b1; rule.ssel = SSEL_SECOND; end
      5'h15: rule.use_gid = 1'b1;
      5'h16: begin rule.use_gid = 1'b1; rule.use_va = 1'b1; rule.ssel = SSEL_SECOND; end
      default: rule.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbinv_rule.sv
module tlbinv_rule
  import tlbinv_pkg::*;
(
  input  inv_rule_t rule,
  input  logic      e_valid,
  input  logic      e_global,
  input  logic      e_stage,
  input  logic      ctx_eq,
  input  logic      gid_eq,
  input  logic      asid_eq,
  input  logic      vpn_eq,
  output logic      kill
);
  logic g_ok, s_ok;

  always_comb begin
    case (rule.gsel)
      GSEL_SET: g_ok = e_global;
      GSEL_CLR: g_ok = !e_global;
      default:  g_ok = 1'b1;
    endcase
    case (rule.ssel)
      SSEL_FIRST:  s_ok = (e_stage == STAGE_FIRST);
      SSEL_SECOND: s_ok = (e_stage == STAGE_SECOND);
      default:     s_ok = 1'b1;
    endcase
    kill = e_valid && rule.legal && g_ok && s_ok
        && (!rule.use_ctx   || ctx_eq)
        && (!rule.use_gid   || gid_eq)
        && (!rule.use_asid  || asid_eq)
        && (!rule.use_va    || vpn_eq)
        && (!rule.g_or_asid || e_global || asid_eq);
  end
endmodule

// File: rtl/tlbinv_pick.sv
module tlbinv_pick #(
  parameter  int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
  import tlbinv_pkg::*;
#(
  parameter  int ENTRIES = 16,
  parameter  int ASID_W  = 10,
  parameter  int VPN_W   = 19,
  parameter  int GID_W   = 8,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctx_we,
  input  logic [GID_W-1:0]  ctx_gid,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IW-1:0]     wr_index,
  input  logic              wr_global,
  input  logic              wr_stage,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [GID_W-1:0]  wr_gid,
  input  logic              inv_req,
  input  logic [4:0]        inv_op,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [GID_W-1:0]  inv_gid,
  input  logic [VPN_W-1:0]  inv_vpn,
  output logic              inv_done,
  output logic              inv_illegal,
  input  logic              srch_en,
  input  logic [ASID_W-1:0] srch_asid,
  input  logic [VPN_W-1:0]  srch_vpn,
  input  logic [GID_W-1:0]  srch_gid,
  output logic              srch_hit,
  output logic [IW-1:0]     srch_idx,
  output logic [IW-1:0]     fill_slot
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] glb_q;
  logic [ENTRIES-1:0] stage_q;
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [GID_W-1:0]   gid_q  [ENTRIES];

  logic [GID_W-1:0]   cur_gid_q;
  logic [IW-1:0]      slot_q;
  logic [IW-1:0]      wr_slot;
  logic [ENTRIES-1:0] kill;
  logic [ENTRIES-1:0] srch_m;
  logic               pick_any;
  logic [IW-1:0]      pick_idx;
  inv_rule_t          cmd_rule;

  assign wr_slot   = wr_random ? slot_q : wr_index;
  assign fill_slot = slot_q;

  tlbinv_decode u_dec (.op(inv_op), .rule(cmd_rule));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    tlbinv_rule u_rule (
      .rule     (cmd_rule),
      .e_valid  (valid_q[i]),
      .e_global (glb_q[i]),
      .e_stage  (stage_q[i]),
      .ctx_eq   (gid_q[i] == cur_gid_q),
      .gid_eq   (gid_q[i] == inv_gid),
      .asid_eq  (asid_q[i] == inv_asid),
      .vpn_eq   (vpn_q[i] == inv_vpn),
      .kill     (kill[i])
    );
    assign srch_m[i] = valid_q[i] && (vpn_q[i] == srch_vpn) && (gid_q[i] == srch_gid)
                    && (glb_q[i] || (asid_q[i] == srch_asid));
  end

  tlbinv_pick #(.N(ENTRIES)) u_pick (.req(srch_m), .any(pick_any), .idx(pick_idx));

  // Entry payload: written one slot per cycle, no reset, RAM-friendly.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      glb_q[wr_slot]   <= wr_global;
      stage_q[wr_slot] <= wr_stage;
      asid_q[wr_slot]  <= wr_asid;
      vpn_q[wr_slot]   <= wr_vpn;
      gid_q[wr_slot]   <= wr_gid;
    end
  end

  // Valid flags: parallel clear, then a write to the same slot wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (inv_req) valid_q <= valid_q & ~kill;
      if (wr_en)   valid_q[wr_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_gid_q   <= '0;
      slot_q      <= '0;
      inv_done    <= 1'b0;
      inv_illegal <= 1'b0;
      srch_hit    <= 1'b0;
      srch_idx    <= '0;
    end else begin
      slot_q      <= slot_q + 1'b1;
      inv_done    <= inv_req && cmd_rule.legal;
      inv_illegal <= inv_req && !cmd_rule.legal;
      if (ctx_we) cur_gid_q <= ctx_gid;
      if (srch_en) begin
        srch_hit <= pick_any;
        srch_idx <= pick_idx;
      end
    end
  end

  // R12
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inv_req && cmd_rule.legal |=> inv_done && !inv_illegal);

  // R11
  illegal_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    inv_req && !cmd_rule.legal && !wr_en |=> inv_illegal && (valid_q == $past(valid_q)));

  // R5
  flush_all_chk: assert property (@(posedge clk) disable iff (rst)
    inv_req && (inv_op == 5'h00) && !wr_en |=> (valid_q == '0));

  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (slot_q == $past(slot_q) + 1'b1));

  // R2
  write_sets_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_slot)]);

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(inv_done && inv_illegal));

endmodule

// File: tb/tlbinv_engine_test.sv
module tlbinv_engine_test;
  localparam int AW = 10, VW = 19, GW = 8, IW = 4;
  localparam logic [GW-1:0] G1 = 8'h21, G2 = 8'h05;
  localparam logic [AW-1:0] A1 = 10'h155, A2 = 10'h0AA;
  localparam logic [VW-1:0] VB = 19'h04000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctx_we = 0; logic [GW-1:0] ctx_gid = 0;
  logic wr_en = 0, wr_random = 0, wr_global = 0, wr_stage = 0;
  logic [IW-1:0] wr_index = 0;
  logic [AW-1:0] wr_asid = 0; logic [VW-1:0] wr_vpn = 0; logic [GW-1:0] wr_gid = 0;
  logic inv_req = 0; logic [4:0] inv_op = 0;
  logic [AW-1:0] inv_asid = 0; logic [GW-1:0] inv_gid = 0; logic [VW-1:0] inv_vpn = 0;
  logic inv_done, inv_illegal;
  logic srch_en = 0; logic [AW-1:0] srch_asid = 0; logic [VW-1:0] srch_vpn = 0;
  logic [GW-1:0] srch_gid = 0;
  logic srch_hit; logic [IW-1:0] srch_idx; logic [IW-1:0] fill_slot;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tlbinv_engine uut (.*);

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(bit rnd, logic [IW-1:0] idx, bit g, bit st,
                    logic [AW-1:0] a, logic [VW-1:0] v, logic [GW-1:0] gd);
    wr_en = 1; wr_random = rnd; wr_index = idx; wr_global = g; wr_stage = st;
    wr_asid = a; wr_vpn = v; wr_gid = gd;
    tick();
    wr_en = 0; wr_random = 0;
  endtask

  task automatic search(logic [AW-1:0] a, logic [VW-1:0] v, logic [GW-1:0] gd);
    srch_en = 1; srch_asid = a; srch_vpn = v; srch_gid = gd;
    tick();
    srch_en = 0;
  endtask

  task automatic cmd(logic [4:0] op, logic [AW-1:0] a, logic [GW-1:0] gd, logic [VW-1:0] v);
    inv_req = 1; inv_op = op; inv_asid = a; inv_gid = gd; inv_vpn = v;
    tick();
    inv_req = 0;
  endtask

  // Population: slot bits -> global, stage, target GID, matching ASID.
  function automatic logic [GW-1:0] pop_gid(int i); return i[2] ? G1 : G2; endfunction
  function automatic logic [AW-1:0] pop_asid(int i); return i[3] ? A1 : A2; endfunction

  task automatic load_pop();
    for (int i = 0; i < 16; i++) wr(0, IW'(i), i[0], i[1], pop_asid(i), VB + VW'(i), pop_gid(i));
  endtask

  function automatic bit op_legal(int op);
    return (op <= 6) || (op >= 9 && op <= 14) || (op >= 16 && op <= 22);
  endfunction

  function automatic string req_of(int op);
    if (!op_legal(op)) return "R11";
    if (op <= 3) return "R5";
    if (op <= 6) return "R6";
    if (op <= 11) return "R7";
    if (op <= 14) return "R8";
    if (op <= 18) return "R9";
    return "R10";
  endfunction

  // Expected removal; current GID is G2, command GID G1, command ASID A1.
  function automatic bit exp_kill(int op, int i, int a);
    bit g = i[0], s2 = i[1], gm = i[2], cm = !i[2], am = i[3], vm = (i == a);
    case (op)
      0:  return 1;
      1:  return cm;
      2:  return cm && g;
      3:  return cm && !g;
      4:  return !g && am;
      5:  return !g && am && vm;
      6:  return vm && (g || am);
      9:  return gm;
      10: return gm && g;
      11: return gm && !g;
      12: return gm && !g && am;
      13: return gm && !g && am && vm;
      14: return gm && g && am && vm;
      16: return !s2;
      17: return s2;
      18: return 1;
      19: return gm && !s2;
      20: return gm && s2;
      21: return gm;
      22: return gm && s2 && vm;
      default: return 0;
    endcase
  endfunction

  initial begin
    #1ms;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    // R1 during reset
    check(!inv_done && !inv_illegal && !srch_hit, "R1", "flags in reset", 0, 0);
    rst = 0;
    search(A1, VB, G1);
    check(!srch_hit, "R1", "search after reset", int'(srch_hit), 0);

    // R3 counter step
    begin
      int s0;
      s0 = int'(fill_slot);
      tick();
      check(int'(fill_slot) == ((s0 + 1) % 16), "R3", "fill_slot step", int'(fill_slot), (s0 + 1) % 16);
    end

    // R3 random write lands in fill_slot
    begin
      int es;
      es = int'(fill_slot);
      wr(1, 0, 0, 0, 10'h011, 19'h00777, 8'h33);
      search(10'h011, 19'h00777, 8'h33);
      check(srch_hit && int'(srch_idx) == es, "R3", "random slot", int'(srch_idx), es);
    end

    // R2 indexed write
    cmd(5'h00, 0, 0, 0);
    wr(0, 4'd7, 0, 1, 10'h022, 19'h00123, 8'h44);
    search(10'h022, 19'h00123, 8'h44);
    check(srch_hit && srch_idx == 4'd7, "R2", "indexed slot", int'(srch_idx), 7);

    // R4 lowest index among duplicates, and global under foreign ASID
    wr(0, 4'd11, 0, 0, 10'h066, 19'h00555, 8'h12);
    wr(0, 4'd4,  0, 0, 10'h066, 19'h00555, 8'h12);
    search(10'h066, 19'h00555, 8'h12);
    check(srch_hit && srch_idx == 4'd4, "R4", "lowest match", int'(srch_idx), 4);
    wr(0, 4'd2, 1, 0, A2, 19'h00999, 8'h12);
    search(A1, 19'h00999, 8'h12);
    check(srch_hit && srch_idx == 4'd2, "R4", "global any asid", int'(srch_idx), 2);
    search(A1, 19'h00555, 8'h12);
    check(!srch_hit, "R4", "asid mismatch misses", int'(srch_hit), 0);

    // R13 current GID register steers op 0x01
    load_pop();
    ctx_we = 1; ctx_gid = G1; tick(); ctx_we = 0;
    cmd(5'h01, 0, 0, 0);
    search(pop_asid(4), VB + 19'd4, pop_gid(4));
    check(!srch_hit, "R13", "ctx G1 entry removed", int'(srch_hit), 0);
    search(pop_asid(0), VB, pop_gid(0));
    check(srch_hit && srch_idx == 4'd0, "R13", "ctx G2 entry kept", int'(srch_hit), 1);

    ctx_we = 1; ctx_gid = G2; tick(); ctx_we = 0;

    // Sweep every code and address choice
    for (int op = 0; op < 32; op++) begin
      for (int a = 0; a < 16; a++) begin
        load_pop();
        cmd(5'(op), A1, G1, VB + VW'(a));
        check(inv_done == op_legal(op), op_legal(op) ? "R12" : "R11", "done pulse",
              int'(inv_done), int'(op_legal(op)));
        check(inv_illegal == !op_legal(op), "R11", "illegal pulse",
              int'(inv_illegal), int'(!op_legal(op)));
        for (int i = 0; i < 16; i++) begin
          bit ev;
          ev = !(op_legal(op) && exp_kill(op, i, a));
          search(pop_asid(i), VB + VW'(i), pop_gid(i));
          if (i == 0)
            check(!inv_done && !inv_illegal, "R12", "pulse one cycle",
                  int'(inv_done || inv_illegal), 0);
          check(srch_hit == ev && (!ev || int'(srch_idx) == i), req_of(op),
                $sformatf("op %0h addr %0d slot %0d", op, a, i), int'(srch_hit), int'(ev));
        end
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule